// File: doc/BRIEF.md
# Quadrature Encoder Input Conditioner

This block sits between the pins of a rotary or linear encoder and the position counter. It takes the two phase inputs and the index input from the pins, with no timing relation to the block clock. Each one first passes through a two-stage synchroniser. A per-channel polarity flip and a per-channel enable gate follow. The last stage is a majority-free run-length filter that rejects short glitches. The outputs are clean levels that downstream edge detection and capture logic can use directly.

The filter does not sample on every clock. It samples on a strobe from a prescaler, and a three-bit select picks the prescaler's divide ratio from a fixed table of non-uniform steps. A single bypass control routes the gated and synchronised levels straight to the outputs. In that case the filter keeps running in the background but its result is not used.

Top module: `enc_input_filter`

## Requirements
- R1: Each raw input reaches the output through exactly two clock registers when the filter is bypassed: a level applied before clock edge k is visible on the output after edge k+1.
- R2: With `filt_bypass` = 1 the outputs follow the conditioned inputs with no run-length qualification; with `filt_bypass` = 0 the filtered levels are driven.
- R3: The sample strobe divides the clock by 1, 2, 4, 16, 32 or 64 for `presc_sel` codes 0, 1, 2, 3, 4 and 5 respectively. With divisor D, a clean level change applied before edge 1 appears on the filtered output after a number of edges between 2D+3 and 3D+2 inclusive.
- R4: `presc_sel` codes 6 and 7 give the same divisor as code 5 (divide by 64).
- R5: The filtered output takes a new level only after three consecutive strobe samples of that level; a pulse lasting two clock cycles at divide-by-1 leaves the output unchanged.
- R6: Each channel has its own inversion bit (`a_inv`, `b_inv`, `idx_inv`); when set, the output is the complement of the raw level.
- R7: A channel whose enable bit (`a_en`, `b_en`, `idx_en`) is 0 drives a constant 0, whatever its raw input and inversion bit are.
- R8: While reset is asserted and directly after it, with inversion bits at 0, all three outputs are 0.
- R9: The channels are independent: activity on one input does not move the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_raw | input | 1 | Phase A from the pin, asynchronous |
| b_raw | input | 1 | Phase B from the pin, asynchronous |
| idx_raw | input | 1 | Index from the pin, asynchronous |
| presc_sel | input | 3 | Sample-rate divisor select |
| filt_bypass | input | 1 | 1 routes unfiltered levels to the outputs |
| a_en | input | 1 | Enable for phase A |
| b_en | input | 1 | Enable for phase B |
| idx_en | input | 1 | Enable for index |
| a_inv | input | 1 | Invert phase A |
| b_inv | input | 1 | Invert phase B |
| idx_inv | input | 1 | Invert index |
| a_clean | output | 1 | Conditioned phase A |
| b_clean | output | 1 | Conditioned phase B |
| idx_clean | output | 1 | Conditioned index |

## Verification
The enable gate and the polarity flip act on the same signal in the same cycle. A disabled channel with inversion set is the case where an implementation that gates before inverting would drive a constant 1. The bench provokes this by clearing the enable and setting the inversion bit, then toggling the raw input through both levels, in both bypass and filtered operation. Each output is judged against zero while the other channels are stimulated. The prescale ratio and the filter's sample count also combine in every filtered transition. For these the bench counts edges from stimulus to output change and compares the count with the window that each divisor implies.

// File: rtl/enc_filt_pkg.sv
package enc_filt_pkg;
  localparam int NUM_CH  = 3;
  localparam int CH_A    = 0;
  localparam int CH_B    = 1;
  localparam int CH_IDX  = 2;
  localparam int SEL_W   = 3;
  localparam int DIV_MAX = 64;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam int RUN_LEN = 3;

  // divisor for a select code; codes past the table saturate at the top ratio
  function automatic int unsigned div_of(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 16;
      3'd4:    return 32;
      default: return DIV_MAX;
    endcase
  endfunction

  // terminal count of the prescaler for a select code
  function automatic logic [CNT_W-1:0] last_of(input logic [SEL_W-1:0] sel);
    int unsigned d;
    d = div_of(sel) - 1;
    return d[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // age counter arms the latency check once the chain is full of real data
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_sync_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (dout == $past(din, STAGES)));
endmodule

// File: rtl/enc_presc.sv
module enc_presc
  import enc_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = last_of(sel);
  // >= so that a shrinking ratio never strands the counter above its limit
  assign tick = (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // with a ratio above 1 and a steady select, strobes never come back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 3'd0) |=> (!tick || !$stable(sel)));

  // codes beyond the table must space strobes like the top ratio
  p_top_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel[2] && sel != 3'd4) |=> (!tick || !$stable(sel)));
endmodule

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter #(
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic dout
);
  localparam int HIST = RUN - 1;

  logic [HIST-1:0] hist_q;
  logic [HIST:0]   window;
  logic            run_hi;
  logic            run_lo;

  assign window = {hist_q, din};
  assign run_hi = &window;
  assign run_lo = ~|window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dout   <= 1'b0;
    end else if (tick) begin
      hist_q <= window[HIST-1:0];
      if (run_hi)      dout <= 1'b1;
      else if (run_lo) dout <= 1'b0;
    end
  end

  p_move_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(tick));

  p_move_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(din) == dout && $past(hist_q[0]) == dout));
endmodule

// File: rtl/enc_input_filter.sv
module enc_input_filter
  import enc_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_raw,
  input  logic             b_raw,
  input  logic             idx_raw,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic             filt_bypass,
  input  logic             a_en,
  input  logic             b_en,
  input  logic             idx_en,
  input  logic             a_inv,
  input  logic             b_inv,
  input  logic             idx_inv,
  output logic             a_clean,
  output logic             b_clean,
  output logic             idx_clean
);
  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] inv_vec;
  logic [NUM_CH-1:0] synced;
  logic [NUM_CH-1:0] gated;
  logic [NUM_CH-1:0] filtered;
  logic [NUM_CH-1:0] clean;
  logic              sample_tick;

  assign raw_vec[CH_A]   = a_raw;
  assign raw_vec[CH_B]   = b_raw;
  assign raw_vec[CH_IDX] = idx_raw;
  assign en_vec[CH_A]    = a_en;
  assign en_vec[CH_B]    = b_en;
  assign en_vec[CH_IDX]  = idx_en;
  assign inv_vec[CH_A]   = a_inv;
  assign inv_vec[CH_B]   = b_inv;
  assign inv_vec[CH_IDX] = idx_inv;

  enc_sync #(.W(NUM_CH), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw_vec),
    .dout (synced)
  );

  enc_presc u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (presc_sel),
    .tick (sample_tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // polarity first, gate last: a disabled lane is 0 even when inverted
    assign gated[c] = en_vec[c] & (synced[c] ^ inv_vec[c]);

    enc_glitch_filter #(.RUN(RUN_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (sample_tick),
      .din  (gated[c]),
      .dout (filtered[c])
    );

    assign clean[c] = filt_bypass ? gated[c] : filtered[c];

    p_off_is_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_bypass && !en_vec[c]) |-> (clean[c] == 1'b0));

    p_bypass_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_bypass && en_vec[c]) |-> (clean[c] == (synced[c] ^ inv_vec[c])));
  end

  assign a_clean   = clean[CH_A];
  assign b_clean   = clean[CH_B];
  assign idx_clean = clean[CH_IDX];
endmodule

// File: tb/enc_input_filter_bench.sv
`timescale 1ns/1ps
module enc_input_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_raw = 0, b_raw = 0, idx_raw = 0;
  logic [2:0] presc_sel = 3'd0;
  logic       filt_bypass = 0;
  logic       a_en = 1, b_en = 1, idx_en = 1;
  logic       a_inv = 0, b_inv = 0, idx_inv = 0;
  logic       a_clean, b_clean, idx_clean;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  enc_input_filter u_enc_input_filter (
    .clk(clk), .rst_n(rst_n),
    .a_raw(a_raw), .b_raw(b_raw), .idx_raw(idx_raw),
    .presc_sel(presc_sel), .filt_bypass(filt_bypass),
    .a_en(a_en), .b_en(b_en), .idx_en(idx_en),
    .a_inv(a_inv), .b_inv(b_inv), .idx_inv(idx_inv),
    .a_clean(a_clean), .b_clean(b_clean), .idx_clean(idx_clean)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_rng(input string req, input int got, input int lo, input int hi);
    total++;
    if (got < lo || got > hi) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  // drive A to lvl at a falling edge, count rising edges until a_clean == want
  task automatic edges_to_a(input logic lvl, input logic want, output int n);
    @(negedge clk);
    a_raw = lvl;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (a_clean != want && n < 400);
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R8 a during reset", a_clean, 0);
    check("R8 idx during reset", idx_clean, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R8 b after reset", b_clean, 0);
  endtask

  task automatic t_bypass();
    int n;
    filt_bypass = 1;
    edges_to_a(1, 1, n);
    check("R1 sync latency rise", n, 2);
    edges_to_a(0, 0, n);
    check("R2 bypass follows fall", n, 2);
    @(negedge clk); a_raw = 1;
    @(negedge clk); a_raw = 0;
    @(negedge clk);
    check("R2 one-cycle pulse passes in bypass", a_clean, 1);
    repeat (3) @(negedge clk);
    filt_bypass = 0;
  endtask

  task automatic t_glitch();
    int seen = 0;
    presc_sel = 3'd0;
    repeat (8) @(negedge clk);
    a_raw = 1;
    repeat (2) @(negedge clk);
    a_raw = 0;
    repeat (10) begin
      @(negedge clk);
      if (a_clean) seen = 1;
    end
    check("R5 two-cycle pulse rejected", seen, 0);
  endtask

  task automatic t_ratio(input logic [2:0] sel, input int d, input string req);
    int n;
    presc_sel = sel;
    edges_to_a(1, 1, n);
    edges_to_a(0, 0, n);
    edges_to_a(1, 1, n);
    check_rng(req, n, 2*d + 3, 3*d + 2);
    edges_to_a(0, 0, n);
  endtask

  task automatic t_invert();
    int n;
    presc_sel = 3'd0;
    b_inv = 1;
    repeat (8) @(negedge clk);
    check("R6 inverted idle B is high", b_clean, 1);
    @(negedge clk); b_raw = 1;
    repeat (8) @(negedge clk);
    check("R6 inverted high B is low", b_clean, 0);
    check("R9 A untouched by B", a_clean, 0);
    b_raw = 0; b_inv = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_disable();
    int seen = 0;
    idx_en = 0; idx_inv = 1;
    for (int m = 0; m < 2; m++) begin
      filt_bypass = (m == 0);
      repeat (6) begin
        @(negedge clk); idx_raw = ~idx_raw;
        repeat (5) @(negedge clk);
        if (idx_clean) seen = 1;
      end
    end
    check("R7 disabled inverted idx stays 0", seen, 0);
    filt_bypass = 0; idx_en = 1;
    idx_raw = 0;
    repeat (8) @(negedge clk);
    check("R6 idx inverted when re-enabled", idx_clean, 1);
    idx_inv = 0;
    repeat (8) @(negedge clk);
    check("R9 idx back to 0, A still 0", idx_clean + a_clean, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bypass();
    t_glitch();
    t_ratio(3'd0, 1,  "R3 div1 window");
    t_ratio(3'd1, 2,  "R3 div2 window");
    t_ratio(3'd2, 4,  "R3 div4 window");
    t_ratio(3'd3, 16, "R3 div16 window");
    t_ratio(3'd4, 32, "R3 div32 window");
    t_ratio(3'd5, 64, "R3 div64 window");
    t_ratio(3'd6, 64, "R4 code6 acts as div64");
    t_ratio(3'd7, 64, "R4 code7 acts as div64");
    t_invert();
    t_disable();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule